// File: doc/BRIEF.md
# Burst Preamble and Payload Whitening Serializer

This block produces the serial bit stream that feeds a burst-mode GMSK transmitter. It emits one bit for each strobe of a bit-clock enable. A start request opens a burst. The block first sends a training preamble so that the far receiver can settle its level and timing recovery. The preamble shape follows the configured Gaussian filter bandwidth. The narrow setting sends doubled-bit alternation, because a plain one-zero toggle gives poor eye peaks through a narrow filter. The wide setting sends single-bit alternation.

After the preamble, payload bits are pulled from a valid/ready stream. Each bit is XORed with a freshly seeded pseudo-random sequence, so that the receiver never sees long constant or toggling runs. The bit flagged as last ends the burst. A one-clock done pulse follows, and the block returns to idle.

The transmitter modulator samples `tx_bit` on the same strobe it uses to advance its own symbol clock. The receive side descrambles with the same sequence, reseeded for each burst.

Top module: `burst_prefix_whitener`

## Requirements
- R1: Under synchronous active-high reset, `tx_bit`, `pre_active`, `burst_done` and `in_ready` are all 0 and the block is idle.
- R2: A `start` seen on any clock while idle opens a burst, whether or not `bit_en` is high. While a preamble or payload is in progress, `start` is ignored.
- R3: The preamble lasts exactly max(`pre_len`, MIN_PRE) strobes, with MIN_PRE = 16. `pre_len` is captured when the burst opens.
- R4: With `bw_mode` = 0 (narrow filter), the preamble bits are 1,1,0,0 repeating, and the first bit is 1.
- R5: With `bw_mode` = 1 (wide filter), the preamble bits are 1,0 repeating, and the first bit is 1.
- R6: `tx_bit` and `pre_active` change only on clock edges where `bit_en` is high. `in_ready` is high only when the block is in payload and `bit_en` is high in that same cycle.
- R7: A payload bit is taken when `in_valid` and `in_ready` are both high. The bit sent is `in_data` XOR w, where w is bit 14 of a 15-bit state. After each taken bit, the state shifts left by one and its new bit 0 is (bit 14 XOR bit 13), which is the polynomial x^15 + x^14 + 1.
- R8: The 15-bit state is loaded with the nonzero SEED (default 15'h2D4B) whenever a burst opens, so every burst uses the same whitening sequence.
- R9: A payload strobe with `in_valid` low sends 0 and leaves the whitening state unchanged.
- R10: Taking a bit with `in_last` high ends the burst. `burst_done` is then high for exactly the one clock after that edge, and the block is idle again.
- R11: `pre_active` is 1 exactly while `tx_bit` carries a preamble bit. Idle strobes send 0 with `pre_active` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable strobe |
| start | input | 1 | Burst open request |
| bw_mode | input | 1 | 0 = narrow filter (doubled alternation), 1 = wide filter (single alternation) |
| pre_len | input | LEN_W | Requested preamble length, clamped up to MIN_PRE |
| in_valid | input | 1 | Payload bit valid |
| in_data | input | 1 | Payload bit |
| in_last | input | 1 | Marks the final payload bit |
| in_ready | output | 1 | Payload bit accepted on this strobe |
| tx_bit | output | 1 | Serial transmit bit |
| pre_active | output | 1 | Current `tx_bit` is a preamble bit |
| burst_done | output | 1 | One-clock pulse after the final payload bit |

## Verification
Two events can land on the same clock: the acceptance of the final payload bit, and a new `start` request. The bench provokes this by raising `start` on exactly that handshake cycle. It expects the request to be dropped, since the block is still in payload there. It then raises `start` again in the cycle where `burst_done` is high, and expects a new burst with a reseeded whitening sequence. A behavioural reference model, compared on every clock, judges both outcomes through the following preamble and payload bits.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_PAY  = 2'd2
    } bfw_state_e;

    typedef enum logic {
        BW_NARROW = 1'b0,
        BW_WIDE   = 1'b1
    } bfw_bw_e;

    // One transmitted symbol and its preamble tag
    typedef struct packed {
        logic data;
        logic pre;
    } bfw_sym_t;

    localparam int LFSR_W       = 15;
    localparam int LFSR_TAP_HI  = 15;
    localparam int LFSR_TAP_LO  = 14;

    // Preamble bit for a given phase; both patterns open with a 1
    function automatic logic pattern_bit(bfw_bw_e bw, logic [1:0] phase);
        if (bw == BW_WIDE)
            return ~phase[0];
        else
            return ~phase[1];
    endfunction

endpackage

// File: rtl/bfw_lfsr.sv
module bfw_lfsr
    import bfw_pkg::*;
#(
    parameter int                 W     = LFSR_W,
    parameter int                 TAP_A = LFSR_TAP_HI,
    parameter int                 TAP_B = LFSR_TAP_LO,
    parameter logic [W-1:0]       SEED  = 15'h2D4B
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic wbit
);
    logic [W-1:0] st_q;
    logic         fb;

    assign fb   = st_q[TAP_A-1] ^ st_q[TAP_B-1];
    assign wbit = st_q[W-1];

    always_ff @(posedge clk) begin
        if (rst || load)
            st_q <= SEED;
        else if (step)
            st_q <= {st_q[W-2:0], fb};
    end

    // R8
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);

    // R9
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(st_q));

endmodule

// File: rtl/bfw_pre_counter.sv
module bfw_pre_counter
    import bfw_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             mode_in,
    input  logic             advance,
    output logic             bit_o,
    output logic             last_o
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    bfw_bw_e          mode_q;

    assign bit_o  = pattern_bit(mode_q, cnt_q[1:0]);
    assign last_o = (cnt_q == len_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            len_q  <= LEN_W'(1);
            mode_q <= BW_NARROW;
        end else if (load) begin
            cnt_q  <= '0;
            len_q  <= len_in;
            mode_q <= bfw_bw_e'(mode_in);
        end else if (advance) begin
            cnt_q  <= cnt_q + LEN_W'(1);
        end
    end

    // R3
    pre_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !last_o) |=> (cnt_q != '0));

endmodule

// File: rtl/burst_prefix_whitener.sv
module burst_prefix_whitener
    import bfw_pkg::*;
#(
    parameter int                  LEN_W   = 8,
    parameter int                  MIN_PRE = 16,
    parameter logic [LFSR_W-1:0]   SEED    = 15'h2D4B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             start,
    input  logic             bw_mode,
    input  logic [LEN_W-1:0] pre_len,
    input  logic             in_valid,
    input  logic             in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             tx_bit,
    output logic             pre_active,
    output logic             burst_done
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_PRE);

    bfw_state_e       state_q;
    bfw_sym_t         sym_q;
    logic             done_q;
    logic [LEN_W-1:0] eff_len;
    logic             open_burst;
    logic             pre_step;
    logic             take;
    logic             pat_bit;
    logic             pat_last;
    logic             wbit;

    assign eff_len    = (pre_len < MIN_LEN) ? MIN_LEN : pre_len;
    assign open_burst = (state_q == ST_IDLE) && start;
    assign pre_step   = (state_q == ST_PRE) && bit_en;
    assign in_ready   = (state_q == ST_PAY) && bit_en;
    assign take       = in_ready && in_valid;

    bfw_pre_counter #(.LEN_W(LEN_W)) pre_i (
        .clk     (clk),
        .rst     (rst),
        .load    (open_burst),
        .len_in  (eff_len),
        .mode_in (bw_mode),
        .advance (pre_step),
        .bit_o   (pat_bit),
        .last_o  (pat_last)
    );

    bfw_lfsr #(.SEED(SEED)) lfsr_i (
        .clk  (clk),
        .rst  (rst),
        .load (open_burst),
        .step (take),
        .wbit (wbit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sym_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (bit_en) sym_q <= '0;
                    if (start)  state_q <= ST_PRE;
                end
                ST_PRE: begin
                    if (bit_en) begin
                        sym_q <= '{data: pat_bit, pre: 1'b1};
                        if (pat_last) state_q <= ST_PAY;
                    end
                end
                ST_PAY: begin
                    if (bit_en) begin
                        if (in_valid) begin
                            sym_q <= '{data: in_data ^ wbit, pre: 1'b0};
                            if (in_last) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        end else begin
                            sym_q <= '0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_bit     = sym_q.data;
    assign pre_active = sym_q.pre;
    assign burst_done = done_q;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> (state_q == ST_IDLE));

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(tx_bit) && $stable(pre_active)));

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PRE) && start) |=> (state_q != ST_IDLE));

    // R11
    pre_before_pay_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_active && bit_en && (state_q == ST_PAY)) |=> !pre_active);

endmodule

// File: tb/burst_prefix_whitener_tb.sv
module burst_prefix_whitener_tb_top;

    localparam int SEED_I = 15'h2D4B;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_en, start, bw_mode, in_valid, in_data, in_last;
    logic [7:0] pre_len;
    logic       in_ready, tx_bit, pre_active, burst_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // reference model state: 0 idle, 1 preamble, 2 payload
    int m_state = 0, m_cnt = 0, m_len = 16, m_mode = 0, m_lfsr = SEED_I;
    bit m_tx = 0, m_pre = 0, m_done = 0;

    always #10 clk = ~clk;

    burst_prefix_whitener dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .start(start), .bw_mode(bw_mode),
        .pre_len(pre_len), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .tx_bit(tx_bit), .pre_active(pre_active),
        .burst_done(burst_done)
    );

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // one clock: drive at negedge, check ready, advance model, check registers
    task automatic step(input bit en, input bit st, input bit v, input bit d,
                        input bit l, input string tag);
        string t_tx;
        bit_en = en; start = st; in_valid = v; in_data = d; in_last = l;
        #1;
        chk(in_ready, (m_state == 2) && en, "R6", "in_ready");
        t_tx = (m_state == 1) ? ((m_mode == 1) ? "R5" : "R4") :
               (m_state == 2) ? (v ? "R7" : "R9") : "R11";
        m_done = 0;
        if (m_state == 0) begin
            if (en) begin m_tx = 0; m_pre = 0; end
            if (st) begin
                m_len   = (pre_len < 16) ? 16 : int'(pre_len);
                m_mode  = bw_mode;
                m_lfsr  = SEED_I;
                m_cnt   = 0;
                m_state = 1;
            end
        end else if (m_state == 1) begin
            if (en) begin
                m_tx  = (m_mode == 1) ? ((m_cnt % 2) == 0) : (((m_cnt / 2) % 2) == 0);
                m_pre = 1;
                m_cnt++;
                if (m_cnt == m_len) m_state = 2;
            end
        end else begin
            if (en) begin
                if (v) begin
                    int wb, fb;
                    wb     = (m_lfsr >> 14) & 1;
                    fb     = ((m_lfsr >> 14) ^ (m_lfsr >> 13)) & 1;
                    m_tx   = d ^ wb[0];
                    m_lfsr = ((m_lfsr << 1) | fb) & 32'h7FFF;
                    m_pre  = 0;
                    if (l) begin m_state = 0; m_done = 1; end
                end else begin
                    m_tx = 0; m_pre = 0;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tx_bit, m_tx, t_tx, {tag, " tx_bit"});
        chk(pre_active, m_pre, "R11", {tag, " pre_active"});
        chk(burst_done, m_done, "R10", {tag, " burst_done"});
    endtask

    function automatic bit data_of(int kind, int i);
        if (kind == 0) return 1'b1;
        if (kind == 1) return i[0];
        return ((i * 7) % 3) == 1;
    endfunction

    // R2 R3: open a burst (if idle), then run it with sparse strobes and gaps
    task automatic run_burst(input bit mode, input int plen, input int nbits,
                             input int kind, input bit start_at_end, input string tag);
        int sent = 0;
        int i = 0;
        int pre_seen = 0;
        bw_mode = mode;
        pre_len = 8'(plen);
        if (m_state == 0) step(0, 1, 0, 0, 0, {tag, " R2 open"});
        while (m_state != 0 && i < 2000) begin
            bit en, v, last;
            en   = (i % 3) != 1;
            v    = (i % 5) != 3;
            last = en && v && (m_state == 2) && (sent == nbits - 1);
            if (en && m_state == 1) pre_seen++;
            // R2: start pulses mid-burst must be ignored
            step(en, ((i % 7) == 0) || (last && start_at_end), v, data_of(kind, sent), last, tag);
            if (en && v && !m_pre && m_tx !== 1'bx && m_state != 1 && pre_seen == m_len) begin
                if (in_ready === 1'b0) sent = sent; // ready sampled already in step
            end
            if (en && v && (m_state == 2 || m_done) && pre_seen == m_len && !m_pre) sent++;
            i++;
        end
        // R3: preamble length observed
        chk(pre_seen == ((plen < 16) ? 16 : plen), 1'b1, "R3", {tag, " preamble length"});
    endtask

    initial begin
        rst = 1; bit_en = 0; start = 0; bw_mode = 0; pre_len = 0;
        in_valid = 0; in_data = 0; in_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(tx_bit, 0, "R1", "tx_bit");
        chk(pre_active, 0, "R1", "pre_active");
        chk(burst_done, 0, "R1", "burst_done");
        chk(in_ready, 0, "R1", "in_ready");
        // idle strobes: nothing happens (R11)
        for (int k = 0; k < 4; k++) step(1, 0, 1, 1, 0, "idle");
        // R4 narrow mode, short length clamped (R3), whitened all-ones payload (R7 R9)
        run_burst(0, 5, 24, 0, 0, "narrow");
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, "gap");
        // R5 wide mode, longer preamble, alternating data
        run_burst(1, 21, 18, 1, 0, "wide");
        // collision: start on the final handshake is dropped, start in done cycle opens (R8)
        run_burst(0, 16, 10, 2, 1, "collide_a");
        chk(m_state == 0, 1'b1, "R2", "model idle after collide_a");
        run_burst(1, 16, 10, 2, 0, "collide_b");
        // R8: reseeded burst repeats identical whitening on identical data
        run_burst(0, 17, 30, 0, 0, "reseed");
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, "tail");
        finish_run();
    end

endmodule